// File: doc/BRIEF.md
# Field Shift-Mask-Merge Unit

This block is a datapath stage that takes a bit field out of a pair of 32-bit words or drops a field into a word. The two operand words are joined into one 64-bit value, with the left word in the upper half. That value is shifted left by a count, and the upper word of the result is kept. A per-bit mask then chooses between this shifted word and a background word.

A 16-bit control descriptor sets the shift count, the mask count and an insert flag. With insert clear, the background is zero, so the block extracts and right-aligns a field. With insert set, the low bits of the mask are also cleared up to the shift count, and the right operand becomes the background. The shifted field is then merged into the right operand.

Descriptors that break the encoding rules still produce a defined result, and a flag marks them. A parameter selects whether the result leaves through a one-cycle register stage with a valid flag, or passes straight through.

Top module: `field_merge_unit`

## Requirements
- R1: The descriptor fields are placed as follows: shift count in bits [5:0], mask count in bits [11:6], insert flag in bit 12, and reserved bits [15:13], which must be zero.
- R2: A shift count of 0 makes the shifted word equal to the left operand.
- R3: For a shift count s from 0 to 32, the shifted word is the upper 32 bits of {left, right} shifted left by s. A count of 32 gives the right operand.
- R4: A mask count m from 0 to 32 sets the lowest m mask bits to one. A count of 0 gives no ones, and a count of 32 gives all ones.
- R5: With insert clear, the result is the shifted word ANDed with the mask, and every bit outside the mask reads zero.
- R6: With insert set, the effective mask is the base mask with its lowest s bits cleared. Result bits inside the effective mask come from the shifted word, and all other bits come from the right operand.
- R7: With insert set and a mask count no greater than the shift count, the result equals the right operand.
- R8: The illegal flag is raised when any of these holds: a reserved bit is nonzero, a count field exceeds 32, or insert is set with the mask count below the shift count. A count field above 32 is used as 32.
- R9: With the output register enabled, the result, the illegal flag and out_valid appear one clock after the input is presented with in_valid. If in_valid is low, out_valid is low the next cycle. Reset clears out_valid, the result and the flag.
- R10: With the output register enabled, a cycle with in_valid low leaves the registered result unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and descriptor are valid this cycle |
| left_word | input | 32 | Upper half of the shifter input |
| right_word | input | 32 | Lower half of the shifter input and the insert background |
| desc | input | 16 | Field descriptor |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Merged field result |
| illegal | output | 1 | Descriptor broke an encoding rule |

## Verification
The bench builds the block with the default 32-bit word and the output register enabled. This tests the one-cycle valid timing and the hold behaviour on idle cycles, together with the full datapath. The 6-bit count fields can then reach every legal count from 0 to 32, plus the out-of-range codes 33 to 63 that exercise clamping. The 16-bit descriptor also leaves three reserved bits that can be set to drive the illegal flag.

// File: rtl/fmu_pkg.sv
package fmu_pkg;
  localparam int unsigned FMU_WORD_W = 32;
  localparam int unsigned FMU_DESC_W = 16;
endpackage

// File: rtl/fmu_decode.sv
module fmu_decode #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DESC_W = 16,
  localparam int unsigned CNT_W = $clog2(WORD_W) + 1
) (
  input  logic [DESC_W-1:0] desc,
  output logic              ins,
  output logic [CNT_W-1:0]  mcnt,
  output logic [CNT_W-1:0]  scnt,
  output logic              bad
);
  localparam int unsigned INS_BIT = 2 * CNT_W;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [CNT_W-1:0] m_raw, s_raw;
  logic             rsvd_set, m_over, s_over;

  always_comb begin
    s_raw    = desc[CNT_W-1:0];
    m_raw    = desc[2*CNT_W-1:CNT_W];
    ins      = desc[INS_BIT];
    rsvd_set = |desc[DESC_W-1:INS_BIT+1];
    m_over   = m_raw > FULL;
    s_over   = s_raw > FULL;
    mcnt     = m_over ? FULL : m_raw;
    scnt     = s_over ? FULL : s_raw;
    bad      = rsvd_set | m_over | s_over | (ins & (mcnt < scnt));
  end
endmodule

// File: rtl/fmu_funnel.sv
module fmu_funnel #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned CNT_W = $clog2(WORD_W) + 1
) (
  input  logic [WORD_W-1:0] left_word,
  input  logic [WORD_W-1:0] right_word,
  input  logic [CNT_W-1:0]  scnt,
  output logic [WORD_W-1:0] shifted
);
  logic [2*WORD_W-1:0] stage [CNT_W+1];

  assign stage[0] = {left_word, right_word};

  for (genvar k = 0; k < CNT_W; k++) begin : g_stage
    assign stage[k+1] = scnt[k] ? (stage[k] << (1 << k)) : stage[k];
  end

  assign shifted = stage[CNT_W][2*WORD_W-1:WORD_W];
endmodule

// File: rtl/fmu_mask.sv
module fmu_mask #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned CNT_W = $clog2(WORD_W) + 1
) (
  input  logic              ins,
  input  logic [CNT_W-1:0]  mcnt,
  input  logic [CNT_W-1:0]  scnt,
  output logic [WORD_W-1:0] mask
);
  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    logic in_base, below_shift;
    assign in_base     = mcnt > CNT_W'(i);
    assign below_shift = scnt > CNT_W'(i);
    assign mask[i]     = in_base & ~(ins & below_shift);
  end
endmodule

// File: rtl/field_merge_unit.sv
module field_merge_unit #(
  parameter int unsigned WORD_W  = fmu_pkg::FMU_WORD_W,
  parameter int unsigned DESC_W  = fmu_pkg::FMU_DESC_W,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] left_word,
  input  logic [WORD_W-1:0] right_word,
  input  logic [DESC_W-1:0] desc,
  output logic              out_valid,
  output logic [WORD_W-1:0] result,
  output logic              illegal
);
  localparam int unsigned CNT_W = $clog2(WORD_W) + 1;

  logic              ins_c, illegal_c;
  logic [CNT_W-1:0]  mcnt_c, scnt_c;
  logic [WORD_W-1:0] shifted_w, mask_w, backdrop_w, merged_w;

  fmu_decode #(.WORD_W(WORD_W), .DESC_W(DESC_W)) u_dec (
    .desc(desc), .ins(ins_c), .mcnt(mcnt_c), .scnt(scnt_c), .bad(illegal_c)
  );

  fmu_funnel #(.WORD_W(WORD_W)) u_fun (
    .left_word(left_word), .right_word(right_word), .scnt(scnt_c), .shifted(shifted_w)
  );

  fmu_mask #(.WORD_W(WORD_W)) u_msk (
    .ins(ins_c), .mcnt(mcnt_c), .scnt(scnt_c), .mask(mask_w)
  );

  assign backdrop_w = ins_c ? right_word : '0;
  assign merged_w   = (shifted_w & mask_w) | (backdrop_w & ~mask_w);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        result    <= '0;
        illegal   <= 1'b0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) begin
          result  <= merged_w;
          illegal <= illegal_c;
        end
      end
    end
  end else begin : g_comb
    assign out_valid = in_valid;
    assign result    = merged_w;
    assign illegal   = illegal_c;
  end
endmodule

// File: rtl/fmu_checker.sv
module fmu_checker #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned DESC_W  = 16,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned CNT_W = $clog2(WORD_W) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [WORD_W-1:0] left_word,
  input logic [WORD_W-1:0] right_word,
  input logic [DESC_W-1:0] desc,
  input logic              out_valid,
  input logic [WORD_W-1:0] result,
  input logic              ins_c,
  input logic [CNT_W-1:0]  mcnt_c,
  input logic [CNT_W-1:0]  scnt_c,
  input logic              illegal_c,
  input logic [WORD_W-1:0] shifted_w,
  input logic [WORD_W-1:0] mask_w,
  input logic [WORD_W-1:0] merged_w
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  a_r2_shift_zero_left: assert property (@(posedge clk) disable iff (!rst_n)
    (scnt_c == '0) |-> (shifted_w == left_word));

  a_r3_shift_full_right: assert property (@(posedge clk) disable iff (!rst_n)
    (scnt_c == FULL) |-> (shifted_w == right_word));

  a_r4_mask_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_c && mcnt_c == FULL) |-> (mask_w == '1));

  a_r5_zero_background: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_c) |-> ((merged_w & ~mask_w) == '0));

  a_r7_right_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_c && mcnt_c <= scnt_c) |-> (merged_w == right_word));

  a_r8_reserved_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (|desc[DESC_W-1:2*CNT_W+1]) |-> illegal_c);

  if (REG_OUT) begin : g_reg_chk
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    a_r9_idle_drops: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));
  end
endmodule

bind field_merge_unit fmu_checker #(
  .WORD_W(WORD_W), .DESC_W(DESC_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .left_word(left_word), .right_word(right_word), .desc(desc),
  .out_valid(out_valid), .result(result),
  .ins_c(ins_c), .mcnt_c(mcnt_c), .scnt_c(scnt_c), .illegal_c(illegal_c),
  .shifted_w(shifted_w), .mask_w(mask_w), .merged_w(merged_w)
);

// File: tb/field_merge_unit_tb.sv
module field_merge_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] left_word = '0, right_word = '0;
  logic [15:0] desc = '0;
  logic        out_valid, illegal;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  field_merge_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .left_word(left_word), .right_word(right_word), .desc(desc),
    .out_valid(out_valid), .result(result), .illegal(illegal)
  );

  // R1 layout: shift [5:0], mask [11:6], insert [12], reserved [15:13]
  function automatic logic [15:0] mk_desc(int rsv, bit ins, int m, int s);
    return {3'(rsv), ins, 6'(m), 6'(s)};
  endfunction

  // Bit-by-bit reference of R3..R8
  function automatic logic [31:0] ref_out(logic [31:0] l, logic [31:0] r, logic [15:0] d);
    logic [63:0] cat;
    logic [31:0] o;
    int m, s;
    bit ins;
    cat = {l, r};
    s = int'(d[5:0]);  if (s > 32) s = 32;
    m = int'(d[11:6]); if (m > 32) m = 32;
    ins = d[12];
    for (int i = 0; i < 32; i++) begin
      bit sel;
      sel = (i < m) && !(ins && i < s);
      o[i] = sel ? cat[i + 32 - s] : (ins ? r[i] : 1'b0);
    end
    return o;
  endfunction

  function automatic bit ref_bad(logic [15:0] d);
    return (d[15:13] != 0) || (d[11:6] > 32) || (d[5:0] > 32) ||
           (d[12] && ((d[11:6] > 32 ? 32 : int'(d[11:6])) < (d[5:0] > 32 ? 32 : int'(d[5:0]))));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(string req, logic [31:0] l, logic [31:0] r, logic [15:0] d);
    left_word = l; right_word = r; desc = d; in_valid = 1'b1;
    @(negedge clk);
    chk(req, result, ref_out(l, r, d));
    chk("R8", 32'(illegal), 32'(ref_bad(d)));
    chk("R9", 32'(out_valid), 32'd1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    logic [31:0] held;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk("R9 reset valid", 32'(out_valid), 0);
    chk("R9 reset result", result, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2, R3: every shift with full mask
    for (int s = 0; s <= 32; s++)
      apply(s == 0 ? "R2" : "R3", 32'h9249_2492, 32'h5397_0C53, mk_desc(0, 0, 32, s));
    // R4: every mask with zero shift
    for (int m = 0; m <= 32; m++)
      apply("R4", 32'hFFFF_FFFF, 32'h0, mk_desc(0, 0, m, 0));
    // R5 small field extracts
    apply("R5", 32'hDB6D_B6DB, 32'h9C4E_2713, mk_desc(0, 0, 8, 4));
    apply("R5", 32'hDB6D_B6DB, 32'h9C4E_2713, mk_desc(0, 0, 1, 16));
    // R6 inserts
    for (int m = 0; m <= 32; m++)
      apply("R6", 32'h0000_0000, 32'hFFFF_FFFF, mk_desc(0, 1, m, 0));
    apply("R6", 32'h1234_5678, 32'hAAAA_5555, mk_desc(0, 1, 8, 2));
    apply("R6", 32'hFFFF_FFFF, 32'h0, mk_desc(0, 1, 32, 7));
    // R7 mask equal to or below shift
    apply("R7", 32'h1234_5678, 32'hCAFE_F00D, mk_desc(0, 1, 8, 8));
    apply("R7", 32'h1234_5678, 32'hCAFE_F00D, mk_desc(0, 1, 2, 9));
    // R8 illegal codes
    apply("R8", 32'h1234_5678, 32'hCAFE_F00D, mk_desc(4, 0, 32, 0));
    apply("R8", 32'h1234_5678, 32'hCAFE_F00D, mk_desc(0, 0, 40, 3));
    apply("R8", 32'h1234_5678, 32'hCAFE_F00D, mk_desc(0, 0, 16, 63));

    // R10 hold and R9 valid drop
    apply("R5", 32'h0F0F_0F0F, 32'h1, mk_desc(0, 0, 20, 5));
    held = result;
    in_valid = 1'b0; left_word = 32'hFFFF_FFFF; desc = mk_desc(0, 0, 32, 0);
    @(negedge clk);
    chk("R10 hold", result, held);
    chk("R9 idle", 32'(out_valid), 0);

    // random: mostly legal descriptors, some arbitrary
    for (int n = 0; n < 400; n++) begin
      logic [15:0] d;
      if (n % 5 == 0) d = 16'($urandom);
      else d = mk_desc(0, $urandom_range(0, 1), $urandom_range(0, 32), $urandom_range(0, 32));
      apply(d[12] ? "R6" : "R5", $urandom, $urandom, d);
    end
    in_valid = 1'b0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule